// File: doc/BRIEF.md
# System Address Decoder with Boot Source Latch

This block turns a 32-bit system bus address into the device and chip-select strobes for one access. The decoding is intentionally partial. Each area uses only a few address bits, so every device image repeats through the area that holds it. Software may therefore reach a device at any of its aliases.

The top three address bits pick one of eight 512 MB areas:

- Area 0 holds the boot ROM.
- Area 1 drives external chip select 1.
- Area 2 drives external chip select 2A on every access. Within this area, address bits 20 and 12 also pick an internal correlator window or an internal peripheral window, and these run alongside 2A.
- Area 3 holds the internal SRAM.
- Area 7 holds a 1 MB window for the on-chip module bus, at its bottom end.
- Every other address is reserved. An access there raises an error flag and no select.

Each access also reports a wait-state profile index, which a separate wait-state counter uses. Chip select 2A and the internal windows behind it share profile 3.

The boot ROM comes in an internal and an external variant. A strap pin chooses between them. The block samples the pin on every clock edge while reset is held low, and again on any edge where the watchdog timeout is high. The sampled value then holds until the next reset or timeout.

Top module: `sys_addr_decoder`

## Requirements
- R1: With `accValid` high, any address below 0x2000_0000 selects the boot ROM with `waitProfile` = 1. `selBootInt` is used when the latched strap is 1, and `selBootExt` when it is 0.
- R2: With `accValid` high, addresses 0x2000_0000 to 0x3FFF_FFFF assert `selCs1` with `waitProfile` = 2.
- R3: With `accValid` high, every address from 0x4000_0000 to 0x5FFF_FFFF asserts `selCs2a` with `waitProfile` = 3.
- R4: Inside 0x4000_0000 to 0x5FFF_FFFF, the internal selects depend only on address bits 20 and 12:
  - bit 20 = 1 and bit 12 = 0 adds `selCorr`;
  - bit 20 = 1 and bit 12 = 1 adds `selPeriph`;
  - bit 20 = 0 adds neither.
- R5: With `accValid` high, addresses 0x6000_0000 to 0x7FFF_FFFF assert `selSram` with `waitProfile` = 4.
- R6: With `accValid` high, addresses 0xE000_0000 to 0xE00F_FFFF assert `selModBus` with `waitProfile` = 5.
- R7: With `accValid` high, addresses 0x8000_0000 to 0xDFFF_FFFF and 0xE010_0000 to 0xFFFF_FFFF assert no select. They raise `errReserved` with `waitProfile` = 0.
- R8: With `accValid` low, every select is 0, `errReserved` is 0 and `waitProfile` is 0, whatever the address.
- R9: The boot strap is sampled at every rising clock edge while `rstN` is low, and at every edge where `wdogExpire` is high. At all other edges the latched value holds, whatever the pin does.
- R10: At most one of these is high at a time: `selBootInt`, `selBootExt`, `selCs1`, `selCs2a`, `selSram`, `selModBus`, `errReserved`. `selCorr` and `selPeriph` are never both high, and either one implies `selCs2a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boot source latch |
| rstN | input | 1 | Active-low reset; the strap is sampled while it is low |
| accValid | input | 1 | Bus access strobe; qualifies every output |
| addr | input | 32 | System bus address |
| bootStrap | input | 1 | Boot source strap; 1 selects internal ROM, 0 external |
| wdogExpire | input | 1 | Watchdog timeout; reloads the boot source latch |
| selBootInt | output | 1 | Internal boot ROM select |
| selBootExt | output | 1 | External boot ROM select |
| selCs1 | output | 1 | External chip select 1 |
| selCs2a | output | 1 | External chip select 2A (whole area 2) |
| selCorr | output | 1 | Internal correlator window select |
| selPeriph | output | 1 | Internal peripheral window select |
| selSram | output | 1 | Internal SRAM select |
| selModBus | output | 1 | On-chip module bus window select |
| errReserved | output | 1 | Access to a reserved region |
| waitProfile | output | 3 | Wait-state profile index (0 none, 1..4 areas, 5 module bus) |

## Verification
The hardest situation to reach is a strap change with no reset. The pin must move away from the latched value, and the latch must either ignore it (R9 hold) or take it only on a watchdog edge. That change is visible only through a later boot-area access. The bench therefore goes through several phases:

- It resets with one strap value and then flips the pin.
- It probes boot aliases to confirm that the latch held.
- It pulses the timeout to load the new value, and probes again.

The alias behaviour is covered by a sweep over all 4096 settings of address bits 31..20, each combined with low-order offsets that toggle bits 12 and 13.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // Area numbers taken from the top address bits
  localparam int AREA_BOOT  = 0;
  localparam int AREA_CS1   = 1;
  localparam int AREA_CS2A  = 2;
  localparam int AREA_SRAM  = 3;
  localparam int AREA_RESV_LO = 4;

  typedef enum logic [2:0] {
    WP_NONE   = 3'd0,
    WP_BOOT   = 3'd1,
    WP_CS1    = 3'd2,
    WP_CS2A   = 3'd3,
    WP_SRAM   = 3'd4,
    WP_MODBUS = 3'd5
  } waitProf_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic accEn;
    logic bootInternal;
  } ctrlStrobe_t;

endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        bootStrap,
  input  logic        wdogExpire,
  output ctrlStrobe_t ctrl
);

  logic bootLatch;

  // Strap is transparent while reset is low and reloads on timeout
  always_ff @(posedge clk) begin
    if (!rstN || wdogExpire) bootLatch <= bootStrap;
  end

  assign ctrl.accEn        = accValid;
  assign ctrl.bootInternal = bootLatch;

  // R9: latch ignores the pin outside reset and timeout
  assert_boot_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wdogExpire |=> $stable(bootLatch));

  // R9: a timeout loads the current strap
  assert_wdog_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdogExpire |=> bootLatch == $past(bootStrap));

endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int AREA_W          = 3,
  parameter int INT_EN_BIT      = 20,
  parameter int INT_PICK_BIT    = 12,
  parameter int MODBUS_SPAN_BIT = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  ctrlStrobe_t       ctrl,
  output logic              selBootInt,
  output logic              selBootExt,
  output logic              selCs1,
  output logic              selCs2a,
  output logic              selCorr,
  output logic              selPeriph,
  output logic              selSram,
  output logic              selModBus,
  output logic              errReserved,
  output logic [2:0]        waitProfile
);

  localparam int NUM_AREAS = 1 << AREA_W;
  localparam int AREA_LSB  = ADDR_W - AREA_W;
  localparam int TAG_W     = AREA_LSB - MODBUS_SPAN_BIT;
  localparam int AREA_TOP  = NUM_AREAS - 1;

  logic [AREA_W-1:0]    areaField;
  logic [NUM_AREAS-1:0] areaHit;
  logic [TAG_W-1:0]     modTag;
  logic                 modHit, resvHit, intWin;
  logic                 unusedAddr;

  assign areaField = addr[ADDR_W-1:AREA_LSB];
  assign modTag    = addr[AREA_LSB-1:MODBUS_SPAN_BIT];

  // One comparator per area
  for (genvar g = 0; g < NUM_AREAS; g++) begin : gAreaHit
    assign areaHit[g] = (areaField == AREA_W'(g));
  end

  assign modHit  = areaHit[AREA_TOP] && (modTag == '0);
  assign resvHit = (|areaHit[AREA_TOP-1:AREA_RESV_LO]) ||
                   (areaHit[AREA_TOP] && !modHit);
  assign intWin  = areaHit[AREA_CS2A] && addr[INT_EN_BIT];

  // Bits outside the partial decode
  assign unusedAddr = ^{addr[INT_PICK_BIT-1:0], addr[INT_EN_BIT-1:INT_PICK_BIT+1]};

  always_comb begin
    selBootInt  = ctrl.accEn && areaHit[AREA_BOOT] && ctrl.bootInternal;
    selBootExt  = ctrl.accEn && areaHit[AREA_BOOT] && !ctrl.bootInternal;
    selCs1      = ctrl.accEn && areaHit[AREA_CS1];
    selCs2a     = ctrl.accEn && areaHit[AREA_CS2A];
    selCorr     = ctrl.accEn && intWin && !addr[INT_PICK_BIT];
    selPeriph   = ctrl.accEn && intWin && addr[INT_PICK_BIT];
    selSram     = ctrl.accEn && areaHit[AREA_SRAM];
    selModBus   = ctrl.accEn && modHit;
    errReserved = ctrl.accEn && resvHit;
  end

  always_comb begin
    waitProfile = WP_NONE;
    if (ctrl.accEn) begin
      unique case (1'b1)
        areaHit[AREA_BOOT]: waitProfile = WP_BOOT;
        areaHit[AREA_CS1]:  waitProfile = WP_CS1;
        areaHit[AREA_CS2A]: waitProfile = WP_CS2A;
        areaHit[AREA_SRAM]: waitProfile = WP_SRAM;
        modHit:             waitProfile = WP_MODBUS;
        default:            waitProfile = WP_NONE;
      endcase
    end
  end

  // R8: idle bus drives nothing
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.accEn |-> !(selBootInt || selBootExt || selCs1 || selCs2a || selCorr ||
                      selPeriph || selSram || selModBus || errReserved) && waitProfile == 3'd0);

  // R10: primary selects exclusive
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selBootInt, selBootExt, selCs1, selCs2a, selSram, selModBus, errReserved}));

  // R4: internal windows ride on chip select 2A
  assert_cs2a_cover_R4: assert property (@(posedge clk) disable iff (!rstN)
    (selCorr || selPeriph) |-> (selCs2a && !(selCorr && selPeriph)));

  // R7: reserved access carries no profile
  assert_err_alone_R7: assert property (@(posedge clk) disable iff (!rstN)
    errReserved |-> waitProfile == 3'd0);

  // R1: boot selects use profile 1
  assert_boot_prof_R1: assert property (@(posedge clk) disable iff (!rstN)
    (selBootInt || selBootExt) |-> waitProfile == 3'd1);

endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
  import sad_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int AREA_W          = 3,
  parameter int INT_EN_BIT      = 20,
  parameter int INT_PICK_BIT    = 12,
  parameter int MODBUS_SPAN_BIT = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bootStrap,
  input  logic              wdogExpire,
  output logic              selBootInt,
  output logic              selBootExt,
  output logic              selCs1,
  output logic              selCs2a,
  output logic              selCorr,
  output logic              selPeriph,
  output logic              selSram,
  output logic              selModBus,
  output logic              errReserved,
  output logic [2:0]        waitProfile
);

  ctrlStrobe_t ctrl;

  sad_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .bootStrap  (bootStrap),
    .wdogExpire (wdogExpire),
    .ctrl       (ctrl)
  );

  sad_datapath #(
    .ADDR_W          (ADDR_W),
    .AREA_W          (AREA_W),
    .INT_EN_BIT      (INT_EN_BIT),
    .INT_PICK_BIT    (INT_PICK_BIT),
    .MODBUS_SPAN_BIT (MODBUS_SPAN_BIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .ctrl        (ctrl),
    .selBootInt  (selBootInt),
    .selBootExt  (selBootExt),
    .selCs1      (selCs1),
    .selCs2a     (selCs2a),
    .selCorr     (selCorr),
    .selPeriph   (selPeriph),
    .selSram     (selSram),
    .selModBus   (selModBus),
    .errReserved (errReserved),
    .waitProfile (waitProfile)
  );

endmodule

// File: tb/sys_addr_decoder_tb.sv
module sys_addr_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] addr = '0;
  logic        bootStrap = 1'b1;
  logic        wdogExpire = 1'b0;
  logic selBootInt, selBootExt, selCs1, selCs2a, selCorr, selPeriph;
  logic selSram, selModBus, errReserved;
  logic [2:0] waitProfile;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit expBootInt = 1'b1;

  always #5 clk = ~clk;

  sys_addr_decoder u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .addr(addr),
    .bootStrap(bootStrap), .wdogExpire(wdogExpire),
    .selBootInt(selBootInt), .selBootExt(selBootExt), .selCs1(selCs1),
    .selCs2a(selCs2a), .selCorr(selCorr), .selPeriph(selPeriph),
    .selSram(selSram), .selModBus(selModBus), .errReserved(errReserved),
    .waitProfile(waitProfile)
  );

  // Packed order: bootInt bootExt cs1 cs2a corr periph sram modbus err wp[2:0]
  function automatic logic [11:0] expOf(bit v, logic [31:0] a, bit bi);
    logic [11:0] e = '0;
    longint ua = a;
    if (!v) return e;
    if (ua < 64'h2000_0000) begin
      e[11] = bi; e[10] = !bi; e[2:0] = 3'd1;            // R1
    end else if (ua < 64'h4000_0000) begin
      e[9] = 1'b1; e[2:0] = 3'd2;                        // R2
    end else if (ua < 64'h6000_0000) begin
      e[8] = 1'b1; e[2:0] = 3'd3;                        // R3
      if ((ua / 64'h10_0000) % 2 == 1) begin              // R4
        if ((ua / 64'h1000) % 2 == 1) e[6] = 1'b1; else e[7] = 1'b1;
      end
    end else if (ua < 64'h8000_0000) begin
      e[5] = 1'b1; e[2:0] = 3'd4;                        // R5
    end else if (ua >= 64'hE000_0000 && ua < 64'hE010_0000) begin
      e[4] = 1'b1; e[2:0] = 3'd5;                        // R6
    end else begin
      e[3] = 1'b1;                                       // R7
    end
    return e;
  endfunction

  function automatic string reqOf(bit v, logic [31:0] a);
    longint ua = a;
    if (!v) return "R8";
    if (ua < 64'h2000_0000) return "R1";
    if (ua < 64'h4000_0000) return "R2";
    if (ua < 64'h6000_0000) return "R3/R4";
    if (ua < 64'h8000_0000) return "R5";
    if (ua >= 64'hE000_0000 && ua < 64'hE010_0000) return "R6";
    return "R7";
  endfunction

  function automatic logic [11:0] gotVec();
    return {selBootInt, selBootExt, selCs1, selCs2a, selCorr, selPeriph,
            selSram, selModBus, errReserved, waitProfile};
  endfunction

  task automatic apply(bit v, logic [31:0] a, string tag);
    logic [11:0] g, e;
    @(negedge clk);
    accValid = v;
    addr = a;
    #1;
    g = gotVec();
    e = expOf(v, a, expBootInt);
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s %s addr=%h got=%b exp=%b", reqOf(v, a), tag, a, g, e);
    end
    if (v) begin
      checks++;
      if (!$onehot0({g[11:8], g[5:3]}) || (g[7] && g[6]) || ((g[7] || g[6]) && !g[8])) begin
        errors++;
        $display("FAIL R10 addr=%h got=%b exp=exclusive", a, g);
      end
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] lows [4] = '{20'h00000, 20'h01000, 20'h02FFC, 20'hFF234};
    // Reset with strap high: internal boot expected
    bootStrap = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expBootInt = 1'b1;
    apply(1'b0, 32'h0000_0000, "reset state idle");

    // R8: idle strobe over many addresses
    for (int h = 0; h < 4096; h += 37)
      apply(1'b0, {h[11:0], 20'hABCDE}, "idle");

    // Sweep bits 31..20 with low offsets toggling bits 12 and 13
    for (int h = 0; h < 4096; h++)
      for (int k = 0; k < 4; k++)
        apply(1'b1, {h[11:0], lows[k]}, "sweep");

    // R1 R9: strap flips without reset, latch holds
    @(negedge clk);
    bootStrap = 1'b0;
    repeat (3) @(negedge clk);
    apply(1'b1, 32'h0000_0010, "R9 hold after strap change");
    apply(1'b1, 32'h1FF0_0000, "R9 hold alias");

    // R9: watchdog timeout loads the low strap
    @(negedge clk);
    wdogExpire = 1'b1;
    @(negedge clk);
    wdogExpire = 1'b0;
    bootStrap = 1'b1;
    expBootInt = 1'b0;
    apply(1'b1, 32'h0012_3450, "R9 wdog load external");
    apply(1'b1, 32'h1000_0000, "R9 external alias");

    // R9: reset with strap high returns to internal
    @(negedge clk);
    rstN = 1'b0;
    bootStrap = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    bootStrap = 1'b0;
    expBootInt = 1'b1;
    apply(1'b1, 32'h0000_0000, "R9 reset reload internal");
    apply(1'b1, 32'h0FFF_FFFC, "R1 internal alias");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule